// File: doc/BRIEF.md
# Programmable SRAM Strobe Timing Sequencer

This block runs one external SRAM-style bus cycle at a time on behalf of one of seven chip-select areas. A request names the area, the direction, the address and (for writes) the data. The sequencer drives the address and chip select, waits a programmable number of setup cycles, and pulses the read or write strobe for a fixed number of access cycles. It then keeps the cycle open for a programmable number of hold cycles and reports completion with a one-cycle pulse.

Setup and hold waits come from a 32-bit timing word that holds one four-bit field per area. Each area can also be marked as SRAM-like or as some other memory type. Areas of other types always run with zero extra waits. The timing word is sampled when a request is accepted, so a change to it affects only later requests.

Top module: `sram_strobe_seq`

## Requirements
- R1: For area n, bit 4n+2 of `timing_cfg` is the setup field: value 1 puts one cycle with chip select on and both strobes off before the strobe, and value 0 puts the strobe in the first cycle after acceptance.
- R2: For area n, bits 4n+1 (high) and 4n (low) of `timing_cfg` give a hold count of 0 to 3. That many cycles follow the last strobe cycle with chip select on and both strobes off.
- R3: The strobe is on for exactly ACCESS_CYC consecutive cycles. `bus_rd` is used when `req_write`=0 and `bus_wr` when `req_write`=1.
- R4: `rd_data` takes the value of `bus_rdata` present during the last read strobe cycle, and shows it from the cycle that follows.
- R5: `bus_cs` is on from the first cycle after acceptance through the last hold cycle, and off otherwise.
- R6: `bus_oe` is on during every chip-select cycle of a write and never during a read.
- R7: `done` is a single-cycle pulse in the cycle after the last hold cycle (or after the last strobe cycle when the hold count is zero). A request is accepted only when the sequencer is idle, and requests presented while busy are dropped.
- R8: When `area_is_sram[n]`=0, the setup and hold fields of area n are ignored and the cycle runs with zero setup and zero hold.
- R9: After reset the sequencer is idle: `bus_cs`, `bus_rd`, `bus_wr`, `bus_oe`, `done` and `rd_data` are all zero.
- R10: `bus_rd` and `bus_wr` are never on together. `bus_addr` shows the accepted address and stays unchanged for as long as `bus_cs` is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_area | input | AREA_W | Target area, 0 to NUM_AREAS-1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| timing_cfg | input | 32 | Packed per-area setup/hold fields |
| area_is_sram | input | NUM_AREAS | 1 = area is SRAM-like and uses its wait fields |
| bus_rdata | input | DATA_W | Data returned by the external device |
| bus_addr | output | ADDR_W | External address |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_wdata | output | DATA_W | External write data |
| bus_oe | output | 1 | Write data output enable |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Read-data capture happens on the same edge that ends the strobe. With a hold count of zero, that edge also moves the sequencer straight to the completion pulse. The bench sets up this case by changing `bus_rdata` on every cycle of every transaction and running all four hold counts in every area. Its check is that the captured word equals the value present during the last strobe cycle, and that `done` rises exactly one cycle later. A second overlap is a new request that is held active until the final hold cycle. The bench checks that the address never moves and that no second cycle starts after `done`.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    localparam int CFG_W     = 32;
    localparam int FIELD_W   = 4;
    localparam int SETUP_OFS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [1:0] hold;
        logic       setup;
    } area_timing_t;

    function automatic area_timing_t unpack_area(input logic [CFG_W-1:0] cfg,
                                                 input int unsigned n);
        area_timing_t t;
        t.setup = cfg[FIELD_W*n + SETUP_OFS];
        t.hold  = cfg[FIELD_W*n +: 2];
        return t;
    endfunction

endpackage

// File: rtl/sram_seq_timing_dec.sv
module sram_seq_timing_dec
    import sram_seq_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int AREA_W    = 3
) (
    input  logic [CFG_W-1:0]     cfg,
    input  logic [NUM_AREAS-1:0] sram_mask,
    input  logic [AREA_W-1:0]    area,
    output area_timing_t         timing
);

    area_timing_t tab [NUM_AREAS];

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        assign tab[g] = sram_mask[g] ? unpack_area(cfg, g) : '0;
    end

    always_comb begin
        timing = '0;
        if (32'(area) < NUM_AREAS) begin
            timing = tab[area];
        end
    end

endmodule

// File: rtl/sram_seq_wait_cnt.sv
module sram_seq_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_seq_pkg::*;
#(
    parameter int NUM_AREAS  = 7,
    parameter int AREA_W     = 3,
    parameter int ADDR_W     = 26,
    parameter int DATA_W     = 32,
    parameter int ACCESS_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [AREA_W-1:0]    req_area,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [31:0]          timing_cfg,
    input  logic [NUM_AREAS-1:0] area_is_sram,
    input  logic [DATA_W-1:0]    bus_rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_cs,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_oe,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done
);

    localparam int MAX_PHASE = (ACCESS_CYC > 4) ? ACCESS_CYC : 4;
    localparam int CNT_W     = $clog2(MAX_PHASE);
    localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACCESS_CYC - 1);

    seq_state_e       st_q, st_nx;
    area_timing_t     dec_tim, tim_q;
    logic             write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic             cnt_load, at_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             accept;

    sram_seq_timing_dec #(
        .NUM_AREAS(NUM_AREAS),
        .AREA_W   (AREA_W)
    ) dec_i (
        .cfg      (timing_cfg),
        .sram_mask(area_is_sram),
        .area     (req_area),
        .timing   (dec_tim)
    );

    sram_seq_wait_cnt #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .load_val(cnt_val),
        .at_zero (at_zero)
    );

    assign accept = req_valid && (st_q == ST_IDLE);

    always_comb begin
        st_nx    = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (dec_tim.setup) begin
                        st_nx   = ST_SETUP;
                        cnt_val = '0;
                    end else begin
                        st_nx   = ST_ACCESS;
                        cnt_val = ACC_LOAD;
                    end
                end
            end
            ST_SETUP: begin
                if (at_zero) begin
                    st_nx    = ST_ACCESS;
                    cnt_load = 1'b1;
                    cnt_val  = ACC_LOAD;
                end
            end
            ST_ACCESS: begin
                if (at_zero) begin
                    if (tim_q.hold != 2'd0) begin
                        st_nx    = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(tim_q.hold) - CNT_W'(1);
                    end else begin
                        st_nx = ST_DONE;
                    end
                end
            end
            ST_HOLD: begin
                if (at_zero) begin
                    st_nx = ST_DONE;
                end
            end
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tim_q   <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_nx;
            if (accept) begin
                tim_q   <= dec_tim;
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if ((st_q == ST_ACCESS) && at_zero && !write_q) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    always_comb begin
        bus_cs = (st_q == ST_SETUP) || (st_q == ST_ACCESS) || (st_q == ST_HOLD);
        bus_rd = (st_q == ST_ACCESS) && !write_q;
        bus_wr = (st_q == ST_ACCESS) && write_q;
        bus_oe = bus_cs && write_q;
        done   = (st_q == ST_DONE);
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign rd_data   = rdata_q;

endmodule

// File: rtl/sram_strobe_seq_chk.sv
module sram_strobe_seq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_oe,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R10

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && $past(bus_cs)) |-> $stable(bus_addr)); // R10

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> bus_cs); // R5

    AST_OE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> bus_cs); // R6

    AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_oe); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_CLOSES_CS: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_cs && $past(bus_cs))); // R7

endmodule

bind sram_strobe_seq sram_strobe_seq_chk #(
    .ADDR_W(ADDR_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .bus_cs  (bus_cs),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_oe  (bus_oe),
    .done    (done),
    .bus_addr(bus_addr)
);

// File: tb/sram_strobe_seq_tb.sv
module sram_strobe_seq_tb_top;

    localparam int NA  = 7;
    localparam int AW  = 3;
    localparam int ADW = 26;
    localparam int DW  = 32;
    localparam int ACC = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid;
    logic [AW-1:0]  req_area;
    logic           req_write;
    logic [ADW-1:0] req_addr;
    logic [DW-1:0]  req_wdata;
    logic [31:0]    timing_cfg;
    logic [NA-1:0]  area_is_sram;
    logic [DW-1:0]  bus_rdata;
    logic [ADW-1:0] bus_addr;
    logic           bus_cs, bus_rd, bus_wr, bus_oe, done;
    logic [DW-1:0]  bus_wdata, rd_data;

    int compared   = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    sram_strobe_seq #(
        .NUM_AREAS(NA), .AREA_W(AW), .ADDR_W(ADW), .DATA_W(DW), .ACCESS_CYC(ACC)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .timing_cfg(timing_cfg), .area_is_sram(area_is_sram), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_oe(bus_oe), .rd_data(rd_data), .done(done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_setup(input logic [31:0] cfg, input logic [NA-1:0] m, input int a);
        return m[a] ? int'(cfg[4*a+2]) : 0;
    endfunction

    function automatic int exp_hold(input logic [31:0] cfg, input logic [NA-1:0] m, input int a);
        return m[a] ? int'({cfg[4*a+1], cfg[4*a]}) : 0;
    endfunction

    task automatic run_txn(input int area, input bit wr, input logic [ADW-1:0] a,
                           input logic [DW-1:0] wd, input logic [31:0] cfg,
                           input logic [NA-1:0] m, input bit poke);
        int su, hd, tot;
        logic [DW-1:0] pat;
        string cstag;
        su  = exp_setup(cfg, m, area);
        hd  = exp_hold(cfg, m, area);
        tot = su + ACC + hd;
        pat = $urandom;
        @(negedge clk);
        req_valid    = 1'b1;
        req_area     = AW'(area);
        req_write    = wr;
        req_addr     = a;
        req_wdata    = wd;
        timing_cfg   = cfg;
        area_is_sram = m;
        bus_rdata    = '0;
        @(negedge clk);
        if (poke) begin
            req_addr  = ~a;
            req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k <= tot + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (!m[area])          cstag = "R8 cs";
            else if (k >= su + ACC) cstag = "R2 cs";
            else                    cstag = "R5 cs";
            check(cstag, 64'(bus_cs), 64'(k < tot));
            check("R3 rd", 64'(bus_rd), 64'(!wr && k >= su && k < su + ACC));
            check("R3 wr", 64'(bus_wr), 64'(wr && k >= su && k < su + ACC));
            if (k == su) check("R1 first strobe", 64'(bus_rd | bus_wr), 64'd1);
            check("R6 oe", 64'(bus_oe), 64'(wr && k < tot));
            check("R7 done", 64'(done), 64'(k == tot));
            if (k < tot) begin
                check("R10 addr", 64'(bus_addr), 64'(a));
                if (wr) check("R6 wdata", 64'(bus_wdata), 64'(wd));
            end
            if (!wr && k == su + ACC) check("R4 rd_data", 64'(rd_data), 64'(pat ^ DW'(su + ACC - 1)));
            bus_rdata = pat ^ DW'(k);
            if (poke && k == tot - 1) req_valid = 1'b0;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C17));
        rst = 1'b1; req_valid = 1'b0; req_area = '0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; timing_cfg = '0; area_is_sram = '0; bus_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle after reset
        check("R9 cs", 64'(bus_cs), 0);
        check("R9 rd", 64'(bus_rd), 0);
        check("R9 wr", 64'(bus_wr), 0);
        check("R9 oe", 64'(bus_oe), 0);
        check("R9 done", 64'(done), 0);
        check("R9 rd_data", 64'(rd_data), 0);

        // R1 R2 R3: every area, setup 0/1, hold 0..3, both directions
        for (int ar = 0; ar < NA; ar++)
            for (int su = 0; su < 2; su++)
                for (int hd = 0; hd < 4; hd++)
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] cfg;
                        cfg = $urandom;
                        cfg[4*ar+2] = su[0];
                        cfg[4*ar +: 2] = hd[1:0];
                        run_txn(ar, w[0], ADW'($urandom), $urandom, cfg, {NA{1'b1}}, 1'b0);
                    end

        // R8: non-SRAM area ignores maximal waits
        for (int ar = 0; ar < NA; ar++) begin
            logic [NA-1:0] m;
            m = {NA{1'b1}};
            m[ar] = 1'b0;
            run_txn(ar, ar[0], ADW'($urandom), $urandom, 32'hFFFF_FFFF, m, 1'b0);
        end

        // R7: requests while busy are dropped
        run_txn(3, 1'b1, 26'h155_AAAA, 32'hCAFE_F00D, 32'h0000_7000, 7'h7F, 1'b1);
        run_txn(5, 1'b0, 26'h0AB_CDEF, 32'h0, 32'h0060_0000, 7'h7F, 1'b1);
        run_txn(0, 1'b0, 26'h000_0001, 32'h0, 32'h0000_0000, 7'h7F, 1'b1);

        // random mix
        for (int i = 0; i < 300; i++)
            run_txn(int'($urandom % NA), 1'($urandom), ADW'($urandom), $urandom,
                    $urandom, NA'($urandom), 1'($urandom % 4 == 0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule